// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block predicts which earlier store a load or store must wait for before it may issue. It keeps two direct-mapped tables. The identifier table is indexed by instruction address and holds a store set identifier with a valid bit. The last-store table is indexed by that identifier and holds the instruction number of the newest fetched store in the set that has not issued, also with a valid bit.

At fetch, the predictor looks up the instruction's set and reports the store instruction number the instruction depends on. A fetched store is then recorded as the newest member of its set. A reported memory order violation places the offending load and store into a common set, allocating or merging identifiers as needed. When a store issues, it releases its last-store entry.

The lookup is combinational within the fetch cycle. All table updates take effect at the next rising clock edge.

Top module: `ssp_top`

## Requirements
- R1: After synchronous reset, every identifier entry is invalid, and no fetch reports a dependence until a violation has been recorded.
- R2: The identifier table index is instruction address bits [IDX_W+1:2] (bits [11:2] by default). Addresses that differ only outside those bits share an entry.
- R3: A fetched load whose identifier entry is valid, and whose set's last-store entry is valid, raises `dep_vld` in the same cycle with `dep_inum` equal to the stored instruction number.
- R4: A fetched store with a valid identifier reports its set's previous unissued store in the same way. From the next cycle on, it becomes that set's last-store entry, so stores in one set chain in program order.
- R5: On a violation where neither instruction has a valid identifier, both receive the value of a round-robin allocation counter. The counter starts at 0 and advances by one modulo 2^SSID_W only on such allocations.
- R6: On a violation where exactly one instruction has a valid identifier, the other instruction's entry is written with that identifier.
- R7: On a violation where both instructions have valid identifiers, both entries are rewritten to the numerically smaller identifier.
- R8: An issuing store with a valid identifier invalidates its set's last-store entry only if that entry holds the store's own instruction number. A fetched store writing the same set in the same cycle takes precedence over the invalidation.
- R9: An instruction whose identifier entry is invalid gets no dependence, and a store in that state writes no last-store entry. With `fetch_vld` low, `dep_vld` is low.
- R10: A fetch in the same cycle as a violation sees the identifier table as it was before that violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | A load or store is being fetched |
| fetch_is_store | input | 1 | Fetched instruction is a store |
| fetch_pc | input | PC_W | Fetched instruction address |
| fetch_inum | input | INUM_W | Instruction number of the fetched instruction |
| dep_vld | output | 1 | Fetched instruction must wait for a store |
| dep_inum | output | INUM_W | Instruction number of the store to wait for |
| iss_vld | input | 1 | A store is issuing |
| iss_pc | input | PC_W | Address of the issuing store |
| iss_inum | input | INUM_W | Instruction number of the issuing store |
| viol_vld | input | 1 | A memory order violation is reported |
| viol_ld_pc | input | PC_W | Address of the offending load |
| viol_st_pc | input | PC_W | Address of the offending store |

## Verification
The bench targets the merge cases. If the smaller-identifier rule (R7) or the copy rule (R6) were wrong, a load would later chain to the wrong store or to none. It checks the guarded release (R8). A design that clears on any issue would drop the newer store in a chain, and one that lets the clear beat a same-cycle fetch would lose the new store. It also checks address aliasing in the index and same-cycle fetch/violation ordering. If either were off, a dependence would appear one cycle early or on the wrong entry.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    // How a violation resolves the two identifier entries
    typedef enum logic [1:0] {
        MRG_ALLOC  = 2'd0,
        MRG_TO_LD  = 2'd1,
        MRG_TO_ST  = 2'd2,
        MRG_MIN    = 2'd3
    } merge_e;

    function automatic merge_e merge_kind(input logic ld_v, input logic st_v);
        merge_e k;
        case ({ld_v, st_v})
            2'b00:   k = MRG_ALLOC;
            2'b10:   k = MRG_TO_LD;
            2'b01:   k = MRG_TO_ST;
            default: k = MRG_MIN;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ssp_idtab.sv
module ssp_idtab #(
    parameter int DEPTH  = 1024,
    parameter int SSID_W = 7,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  fa_idx,
    output logic              fa_vld,
    output logic [SSID_W-1:0] fa_id,
    input  logic [IDX_W-1:0]  is_idx,
    output logic              is_vld,
    output logic [SSID_W-1:0] is_id,
    input  logic              viol_vld,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [IDX_W-1:0]  st_idx,
    output logic              ld_hit,
    output logic              st_hit,
    output logic [SSID_W-1:0] alloc_id
);
    import ssp_pkg::*;

    logic [DEPTH-1:0]  vld_q;
    logic [SSID_W-1:0] id_q [DEPTH];
    logic [SSID_W-1:0] ld_id, st_id, new_id;
    merge_e            kind;

    always_comb begin
        fa_vld = vld_q[fa_idx];
        fa_id  = id_q[fa_idx];
        is_vld = vld_q[is_idx];
        is_id  = id_q[is_idx];
        ld_hit = vld_q[ld_idx];
        st_hit = vld_q[st_idx];
        ld_id  = id_q[ld_idx];
        st_id  = id_q[st_idx];
        kind   = merge_kind(ld_hit, st_hit);
        case (kind)
            MRG_ALLOC: new_id = alloc_id;
            MRG_TO_LD: new_id = ld_id;
            MRG_TO_ST: new_id = st_id;
            default:   new_id = (ld_id < st_id) ? ld_id : st_id;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q    <= '0;
            alloc_id <= '0;
        end else if (viol_vld) begin
            vld_q[ld_idx] <= 1'b1;
            vld_q[st_idx] <= 1'b1;
            if (kind == MRG_ALLOC) alloc_id <= alloc_id + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && viol_vld) begin
            id_q[ld_idx] <= new_id;
            id_q[st_idx] <= new_id;
        end
    end

endmodule

// File: rtl/ssp_lastst.sv
module ssp_lastst #(
    parameter int SSID_W = 7,
    parameter int INUM_W = 8,
    localparam int DEPTH = 1 << SSID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SSID_W-1:0] rd_id,
    output logic              rd_vld,
    output logic [INUM_W-1:0] rd_inum,
    input  logic              wr_en,
    input  logic [SSID_W-1:0] wr_id,
    input  logic [INUM_W-1:0] wr_inum,
    input  logic              clr_en,
    input  logic [SSID_W-1:0] clr_id,
    input  logic [INUM_W-1:0] clr_inum
);
    logic [DEPTH-1:0]  vld_q;
    logic [INUM_W-1:0] inum_q [DEPTH];
    logic              clr_go;

    assign rd_vld  = vld_q[rd_id];
    assign rd_inum = inum_q[rd_id];
    assign clr_go  = clr_en && vld_q[clr_id] && (inum_q[clr_id] == clr_inum)
                     && !(wr_en && (wr_id == clr_id));

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            if (clr_go) vld_q[clr_id] <= 1'b0;
            if (wr_en)  vld_q[wr_id]  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en) inum_q[wr_id] <= wr_inum;
    end

endmodule

// File: rtl/ssp_top.sv
module ssp_top #(
    parameter int PC_W       = 32,
    parameter int SSIT_DEPTH = 1024,
    parameter int SSID_W     = 7,
    parameter int INUM_W     = 8,
    localparam int IDX_W     = $clog2(SSIT_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_vld,
    input  logic              fetch_is_store,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic [INUM_W-1:0] fetch_inum,
    output logic              dep_vld,
    output logic [INUM_W-1:0] dep_inum,
    input  logic              iss_vld,
    input  logic [PC_W-1:0]   iss_pc,
    input  logic [INUM_W-1:0] iss_inum,
    input  logic              viol_vld,
    input  logic [PC_W-1:0]   viol_ld_pc,
    input  logic [PC_W-1:0]   viol_st_pc
);
    logic              f_id_vld, i_id_vld, v_ld_vld, v_st_vld;
    logic [SSID_W-1:0] f_id, i_id, alloc_id;
    logic              l_vld;
    logic [INUM_W-1:0] l_inum;

    ssp_idtab #(.DEPTH(SSIT_DEPTH), .SSID_W(SSID_W)) u_idtab (
        .clk      (clk),
        .rst      (rst),
        .fa_idx   (fetch_pc[IDX_W+1:2]),
        .fa_vld   (f_id_vld),
        .fa_id    (f_id),
        .is_idx   (iss_pc[IDX_W+1:2]),
        .is_vld   (i_id_vld),
        .is_id    (i_id),
        .viol_vld (viol_vld),
        .ld_idx   (viol_ld_pc[IDX_W+1:2]),
        .st_idx   (viol_st_pc[IDX_W+1:2]),
        .ld_hit   (v_ld_vld),
        .st_hit   (v_st_vld),
        .alloc_id (alloc_id)
    );

    ssp_lastst #(.SSID_W(SSID_W), .INUM_W(INUM_W)) u_lastst (
        .clk      (clk),
        .rst      (rst),
        .rd_id    (f_id),
        .rd_vld   (l_vld),
        .rd_inum  (l_inum),
        .wr_en    (fetch_vld && fetch_is_store && f_id_vld),
        .wr_id    (f_id),
        .wr_inum  (fetch_inum),
        .clr_en   (iss_vld && i_id_vld),
        .clr_id   (i_id),
        .clr_inum (iss_inum)
    );

    assign dep_vld  = fetch_vld && f_id_vld && l_vld;
    assign dep_inum = l_inum;

endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
    parameter int SSID_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_vld,
    input logic              dep_vld,
    input logic              f_id_vld,
    input logic              viol_vld,
    input logic              v_ld_vld,
    input logic              v_st_vld,
    input logic [SSID_W-1:0] alloc_id
);
    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !dep_vld);

    // R9
    no_fetch_no_dep_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_vld |-> !dep_vld);

    // R3
    dep_needs_id_chk: assert property (@(posedge clk) disable iff (rst)
        dep_vld |-> f_id_vld);

    // R5
    alloc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_vld && !v_ld_vld && !v_st_vld) |=> alloc_id == SSID_W'($past(alloc_id) + 1'b1));

    // R5
    alloc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(viol_vld && !v_ld_vld && !v_st_vld) |=> $stable(alloc_id));

endmodule

bind ssp_top ssp_chk #(.SSID_W(SSID_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fetch_vld (fetch_vld),
    .dep_vld   (dep_vld),
    .f_id_vld  (f_id_vld),
    .viol_vld  (viol_vld),
    .v_ld_vld  (v_ld_vld),
    .v_st_vld  (v_st_vld),
    .alloc_id  (alloc_id)
);

// File: tb/ssp_top_tb.sv
`timescale 1ns/1ps
module ssp_top_tb;
    localparam int PC_W = 32, DEPTH = 1024, SSID_W = 7, INUM_W = 8;
    localparam int IDX_W = 10, LDEPTH = 128;

    logic clk = 1'b0, rst = 1'b1;
    logic fetch_vld = 0, fetch_is_store = 0, iss_vld = 0, viol_vld = 0;
    logic [PC_W-1:0] fetch_pc = '0, iss_pc = '0, viol_ld_pc = '0, viol_st_pc = '0;
    logic [INUM_W-1:0] fetch_inum = '0, iss_inum = '0;
    logic dep_vld;
    logic [INUM_W-1:0] dep_inum;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // model state
    bit              m_iv [DEPTH];
    bit [SSID_W-1:0] m_id [DEPTH];
    bit              m_lv [LDEPTH];
    bit [INUM_W-1:0] m_ln [LDEPTH];
    bit [SSID_W-1:0] m_ctr;

    always #4 clk = ~clk;

    ssp_top u_dut (.*);

    function automatic int ix(input logic [PC_W-1:0] pc);
        return int'(pc[IDX_W+1:2]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_iv[i] = 0;
        for (int i = 0; i < LDEPTH; i++) m_lv[i] = 0;
        m_ctr = 0;
    endtask

    task automatic cyc(input bit fv, input bit fs, input logic [PC_W-1:0] fpc,
                       input logic [INUM_W-1:0] fn, input bit iv, input logic [PC_W-1:0] ipc,
                       input logic [INUM_W-1:0] inn, input bit vv,
                       input logic [PC_W-1:0] lpc, input logic [PC_W-1:0] spc,
                       input string tag);
        bit ev; bit [INUM_W-1:0] en;
        int fi, ii, li, si; bit [SSID_W-1:0] fid, iid, nid;
        @(negedge clk);
        fetch_vld = fv; fetch_is_store = fs; fetch_pc = fpc; fetch_inum = fn;
        iss_vld = iv; iss_pc = ipc; iss_inum = inn;
        viol_vld = vv; viol_ld_pc = lpc; viol_st_pc = spc;
        #1;
        fi = ix(fpc); ii = ix(ipc); li = ix(lpc); si = ix(spc);
        fid = m_id[fi]; iid = m_id[ii];
        ev = fv && m_iv[fi] && m_lv[fid];
        en = m_ln[fid];
        n_tests++;
        if (dep_vld !== ev || (ev && dep_inum !== en)) begin
            n_fail++;
            $display("FAIL %s: dep got %b/%0d expected %b/%0d", tag, dep_vld, dep_inum, ev, en);
        end
        // next state, all from pre-state
        begin
            bit wr; bit wr_done_lv;
            wr = fv && fs && m_iv[fi];
            if (iv && m_iv[ii] && m_lv[iid] && m_ln[iid] == inn && !(wr && fid == iid))
                m_lv[iid] = 0;
            if (wr) begin m_lv[fid] = 1; m_ln[fid] = fn; end
            wr_done_lv = 0;
            if (vv) begin
                if (!m_iv[li] && !m_iv[si]) begin nid = m_ctr; m_ctr = m_ctr + 1'b1; end
                else if (m_iv[li] && !m_iv[si]) nid = m_id[li];
                else if (!m_iv[li]) nid = m_id[si];
                else nid = (m_id[li] < m_id[si]) ? m_id[li] : m_id[si];
                m_iv[li] = 1; m_iv[si] = 1; m_id[li] = nid; m_id[si] = nid;
            end
        end
        @(posedge clk);
    endtask

    localparam logic [PC_W-1:0] PA = 32'h100, PB = 32'h204, PC_ = 32'h308,
                                PD = 32'h40C, PE = 32'h510, PF = 32'h614;

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: reset state
        cyc(1,0,PA,0, 0,0,0, 0,0,0, "R1");
        // R9: store without set writes nothing
        cyc(1,1,PB,8'd5, 0,0,0, 0,0,0, "R9");
        cyc(1,0,PB,0, 0,0,0, 0,0,0, "R9");
        // R5: allocate id 0 to A,B
        cyc(0,0,0,0, 0,0,0, 1,PA,PB, "R5");
        cyc(1,1,PB,8'd10, 0,0,0, 0,0,0, "R4");
        cyc(1,0,PA,0, 0,0,0, 0,0,0, "R3");
        cyc(1,1,PB,8'd11, 0,0,0, 0,0,0, "R4");
        // R8: older store issue does not clear
        cyc(0,0,0,0, 1,PB,8'd10, 0,0,0, "R8");
        cyc(1,0,PA,0, 0,0,0, 0,0,0, "R8");
        cyc(0,0,0,0, 1,PB,8'd11, 0,0,0, "R8");
        cyc(1,0,PA,0, 0,0,0, 0,0,0, "R8");
        // R5 second allocation, R6 copy
        cyc(0,0,0,0, 0,0,0, 1,PC_,PD, "R5");
        cyc(0,0,0,0, 0,0,0, 1,PE,PB, "R6");
        cyc(1,1,PB,8'd15, 0,0,0, 0,0,0, "R6");
        cyc(1,0,PE,0, 0,0,0, 0,0,0, "R6");
        // R7: merge C(1) with B(0) -> 0
        cyc(0,0,0,0, 0,0,0, 1,PC_,PB, "R7");
        cyc(1,1,PB,8'd20, 0,0,0, 0,0,0, "R7");
        cyc(1,0,PC_,0, 0,0,0, 0,0,0, "R7");
        // R2: alias of C
        cyc(1,0,PC_ + 32'h1000,0, 0,0,0, 0,0,0, "R2");
        // R8: same-cycle fetch write beats clear
        cyc(1,1,PB,8'd30, 1,PB,8'd20, 0,0,0, "R8");
        cyc(1,0,PC_,0, 0,0,0, 0,0,0, "R8");
        // R10: fetch beside violation sees old table
        cyc(1,0,PF,0, 0,0,0, 1,PF,PB, "R10");
        cyc(1,0,PF,0, 0,0,0, 0,0,0, "R10");
        // random mix over a small address pool
        for (int n = 0; n < 4000; n++) begin
            logic [PC_W-1:0] p0, p1, p2, p3;
            bit fs;
            p0 = PC_W'(($urandom % 12) * 4 + 32'h40 + (($urandom % 2) << 12));
            p1 = PC_W'(($urandom % 12) * 4 + 32'h40);
            p2 = PC_W'(($urandom % 12) * 4 + 32'h40);
            p3 = PC_W'(($urandom % 12) * 4 + 32'h40);
            fs = $urandom % 2;
            cyc(($urandom % 4) != 0, fs, p0, INUM_W'($urandom),
                ($urandom % 3) == 0, p1, INUM_W'($urandom % 8),
                ($urandom % 8) == 0, p2, p3, fs ? "R4" : "R3");
            if (n == 2000) begin
                @(negedge clk); rst = 1; model_reset();
                @(negedge clk); rst = 0;
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule